// File: doc/BRIEF.md
# I2C Bus Master Controller with Bus Monitor

This block acts as a master on a two-wire I2C bus. It drives the clock and data lines as open-drain outputs. An output enable of 1 pulls a line low, and 0 releases it. It reads both lines back. A small sequencer turns single-cycle command strobes into bus waveforms: START, repeated START, STOP, byte transmit, byte receive, and sending an acknowledge bit. A baud-rate counter sets the length of each clock phase.

A passive monitor watches the bus at all times, whoever drives it. It records whether the last condition seen was a START or a STOP. A new transfer may claim the bus only when the last condition was a STOP, or when no condition has been seen at all.

A single sticky event flag reports bus conditions and finished commands. Two further sticky flags report a write that arrives during a transfer and a lost bus (data line low while the master releases it). Software-facing registers are out of scope. A system integrator connects the strobes, status outputs and line pins directly.

Top module: `i2c_master_core`

## Requirements
- R1: After reset both line enables are 0 (released), and `busy`, `irq`, `wcol`, `bcol`, `sta_seen`, `sto_seen` and `ack_stat` are all 0.
- R2: `cmd_start` from the idle state first pulls SDA low while SCL is high, then pulls SCL low. The block then waits in an owning state with both enables at 1.
- R3: The monitor sets `sta_seen` and clears `sto_seen` when SDA falls while SCL is high. It does the reverse when SDA rises while SCL is high. Either event sets `irq`, whichever device caused it. The two status bits are never both 1.
- R4: `cmd_start` is accepted only when `sto_seen` is 1 or both status bits are 0. Otherwise it is dropped: no line moves, `busy` stays 0 and `irq` is not set.
- R5: `irq` is set when START, repeated START, STOP, byte transmit, byte receive or acknowledge transmit completes. It stays 1 until an `irq_clr` pulse. A set in the same cycle wins over the clear.
- R6: Each SCL high phase lasts `divisor`+1 clock cycles, counted from the first cycle SCL is sampled high. While another device holds SCL low, the count does not advance.
- R7: A `wr_strobe` while owning the bus sends `wr_data` MSB first. On the ninth clock the block releases SDA and samples it into `ack_stat` (1 means no acknowledge).
- R8: `cmd_rcv` clocks in 8 bits MSB first, with SDA released throughout, and places them on `rd_data`. `cmd_ack` then drives `ack_value` on one further clock (0 pulls SDA low).
- R9: A `wr_strobe` while `busy` is 1 sets `wcol`, and the byte on the bus is the one already in progress.
- R10: If SDA reads low during a transmit high phase in which the block released SDA, `bcol` is set. The block then returns to idle with both lines released. The acknowledge clock of a transmit is excluded.
- R11: Completing START or repeated START clears `ack_stat`. Completing STOP returns to idle with both lines released and `busy` 0.
- R12: While `enable` is 0 both status bits are 0, both lines are released and `busy` is 0.
- R13: `irq_clr` clears `irq`, `wcol` and `bcol` in the same edge, unless a new set arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 aborts and clears the monitor |
| divisor | input | DIV_W | Baud counter reload value |
| cmd_start | input | 1 | Request START |
| cmd_rstart | input | 1 | Request repeated START |
| cmd_stop | input | 1 | Request STOP |
| cmd_rcv | input | 1 | Request byte receive |
| cmd_ack | input | 1 | Request acknowledge transmit |
| ack_value | input | 1 | Acknowledge level to send (0 = ACK) |
| wr_strobe | input | 1 | Write data buffer and start transmit |
| wr_data | input | DATA_W | Byte to transmit |
| irq_clr | input | 1 | Clear sticky flags |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rd_data | output | DATA_W | Last received byte |
| ack_stat | output | 1 | Acknowledge level seen after transmit |
| busy | output | 1 | A command sequence is running |
| sta_seen | output | 1 | Last bus condition was START |
| sto_seen | output | 1 | Last bus condition was STOP |
| irq | output | 1 | Sticky event flag |
| wcol | output | 1 | Sticky write-collision flag |
| bcol | output | 1 | Sticky bus-collision flag |

## Verification
A wrong sequencer step shows up in the line enables within one baud period. Examples are a misplaced SDA change, a missing clock or a byte sent LSB first, all seen as a wrong captured byte or a monitor flag that never sets. A faulty monitor state shows up at once as a wrongly accepted or refused START. A baud counter that ignores a held-low SCL shows up as a shortened high phase on the first bit after the hold.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_START,
        ST_RSTART,
        ST_STOP,
        ST_TX,
        ST_RX,
        ST_ACK
    } seq_st_e;
endpackage

// File: rtl/i2cm_brg.sv
module i2cm_brg #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             hold,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } brg_s;

    brg_s brg_q, brg_d;

    always_comb begin
        brg_d = brg_q;
        tick  = 1'b0;
        if (load) begin
            brg_d.cnt = divisor;
        end else if (!hold) begin
            if (brg_q.cnt == '0) begin
                tick      = 1'b1;
                brg_d.cnt = divisor;
            end else begin
                brg_d.cnt = brg_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) brg_q <= '0;
        else        brg_q <= brg_d;
    end

    // R6: with a nonzero divisor two ticks are never adjacent
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor != '0) |=> !tick);
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_det,
    output logic stop_det,
    output logic sta_seen,
    output logic sto_seen
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic sta;
        logic sto;
    } mon_s;

    mon_s mon_q, mon_d;

    always_comb begin
        start_det = enable & mon_q.scl_p & scl_i & mon_q.sda_p & ~sda_i;
        stop_det  = enable & mon_q.scl_p & scl_i & ~mon_q.sda_p & sda_i;
        mon_d       = mon_q;
        mon_d.scl_p = scl_i;
        mon_d.sda_p = sda_i;
        if (!enable) begin
            mon_d.sta = 1'b0;
            mon_d.sto = 1'b0;
        end else if (start_det) begin
            mon_d.sta = 1'b1;
            mon_d.sto = 1'b0;
        end else if (stop_det) begin
            mon_d.sta = 1'b0;
            mon_d.sto = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '{scl_p: 1'b1, sda_p: 1'b1, sta: 1'b0, sto: 1'b0};
        else        mon_q <= mon_d;
    end

    assign sta_seen = mon_q.sta;
    assign sto_seen = mon_q.sto;

    p_sp_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sta_seen && sto_seen));
    p_start_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (sta_seen && !sto_seen));
    p_disable_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sta_seen && !sto_seen));
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bus_free,
    input  logic              cmd_start,
    input  logic              cmd_rstart,
    input  logic              cmd_stop,
    input  logic              cmd_rcv,
    input  logic              cmd_ack,
    input  logic              ack_value,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              tick,
    output logic              brg_load,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack_stat,
    output logic              busy,
    output logic              done,
    output logic              wcol_evt,
    output logic              bcol_evt
);
    localparam int BCNT_W = $clog2(DATA_W + 1);
    localparam logic [BCNT_W-1:0] LAST_TX = BCNT_W'(DATA_W);
    localparam logic [BCNT_W-1:0] LAST_RX = BCNT_W'(DATA_W - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        step;
        logic [BCNT_W-1:0] bitcnt;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] rdbuf;
        logic              scl_oe;
        logic              sda_oe;
        logic              ack;
    } seq_s;

    seq_s seq_q, seq_d;
    logic              in_xfer;
    logic              hi_sampled;
    logic [BCNT_W-1:0] nxt_bit;
    logic [DATA_W-1:0] rx_shift;

    always_comb begin
        seq_d      = seq_q;
        done       = 1'b0;
        wcol_evt   = 1'b0;
        bcol_evt   = 1'b0;
        brg_load   = 1'b0;
        in_xfer    = (seq_q.st != ST_IDLE) && (seq_q.st != ST_HOLD);
        hi_sampled = (seq_q.step == 2'd1) && !seq_q.scl_oe && scl_i;
        nxt_bit    = seq_q.bitcnt + 1'b1;
        rx_shift   = {seq_q.shreg[DATA_W-2:0], sda_i};

        if (wr_strobe && in_xfer) wcol_evt = 1'b1;

        if (!enable) begin
            seq_d.st     = ST_IDLE;
            seq_d.step   = 2'd0;
            seq_d.scl_oe = 1'b0;
            seq_d.sda_oe = 1'b0;
        end else begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (cmd_start && bus_free) begin
                        seq_d.st     = ST_START;
                        seq_d.step   = 2'd0;
                        seq_d.scl_oe = 1'b0;
                        seq_d.sda_oe = 1'b0;
                        brg_load     = 1'b1;
                    end
                end
                ST_HOLD: begin
                    seq_d.step   = 2'd0;
                    seq_d.bitcnt = '0;
                    if (cmd_rstart) begin
                        seq_d.st     = ST_RSTART;
                        seq_d.sda_oe = 1'b0;
                        brg_load     = 1'b1;
                    end else if (cmd_stop) begin
                        seq_d.st     = ST_STOP;
                        seq_d.sda_oe = 1'b1;
                        brg_load     = 1'b1;
                    end else if (cmd_rcv) begin
                        seq_d.st     = ST_RX;
                        seq_d.sda_oe = 1'b0;
                        brg_load     = 1'b1;
                    end else if (cmd_ack) begin
                        seq_d.st     = ST_ACK;
                        seq_d.sda_oe = !ack_value;
                        brg_load     = 1'b1;
                    end else if (wr_strobe) begin
                        seq_d.st     = ST_TX;
                        seq_d.shreg  = wr_data;
                        seq_d.sda_oe = !wr_data[DATA_W-1];
                        brg_load     = 1'b1;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        unique case (seq_q.step)
                            2'd0:    begin seq_d.step = 2'd1; seq_d.sda_oe = 1'b1; end
                            2'd1:    begin seq_d.step = 2'd2; seq_d.scl_oe = 1'b1; end
                            default: begin
                                seq_d.st   = ST_HOLD;
                                seq_d.step = 2'd0;
                                seq_d.ack  = 1'b0;
                                done       = 1'b1;
                            end
                        endcase
                    end
                end
                ST_RSTART: begin
                    if (tick) begin
                        unique case (seq_q.step)
                            2'd0: begin seq_d.step = 2'd1; seq_d.scl_oe = 1'b0; end
                            2'd1: begin seq_d.step = 2'd2; seq_d.sda_oe = 1'b1; end
                            2'd2: begin seq_d.step = 2'd3; seq_d.scl_oe = 1'b1; end
                            default: begin
                                seq_d.st   = ST_HOLD;
                                seq_d.step = 2'd0;
                                seq_d.ack  = 1'b0;
                                done       = 1'b1;
                            end
                        endcase
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        unique case (seq_q.step)
                            2'd0:    begin seq_d.step = 2'd1; seq_d.scl_oe = 1'b0; end
                            2'd1:    begin seq_d.step = 2'd2; seq_d.sda_oe = 1'b0; end
                            default: begin
                                seq_d.st   = ST_IDLE;
                                seq_d.step = 2'd0;
                                done       = 1'b1;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (hi_sampled && !seq_q.sda_oe && !sda_i && seq_q.bitcnt != LAST_TX) begin
                        bcol_evt     = 1'b1;
                        seq_d.st     = ST_IDLE;
                        seq_d.step   = 2'd0;
                        seq_d.scl_oe = 1'b0;
                        seq_d.sda_oe = 1'b0;
                    end else if (tick) begin
                        if (seq_q.step == 2'd0) begin
                            seq_d.step   = 2'd1;
                            seq_d.scl_oe = 1'b0;
                        end else if (seq_q.bitcnt == LAST_TX) begin
                            seq_d.ack    = sda_i;
                            seq_d.st     = ST_HOLD;
                            seq_d.step   = 2'd0;
                            seq_d.scl_oe = 1'b1;
                            done         = 1'b1;
                        end else begin
                            seq_d.step   = 2'd0;
                            seq_d.scl_oe = 1'b1;
                            seq_d.bitcnt = nxt_bit;
                            seq_d.shreg  = {seq_q.shreg[DATA_W-2:0], 1'b0};
                            seq_d.sda_oe = (nxt_bit == LAST_TX) ? 1'b0 : !seq_q.shreg[DATA_W-2];
                        end
                    end
                end
                ST_RX: begin
                    if (tick) begin
                        if (seq_q.step == 2'd0) begin
                            seq_d.step   = 2'd1;
                            seq_d.scl_oe = 1'b0;
                        end else begin
                            seq_d.shreg  = rx_shift;
                            seq_d.step   = 2'd0;
                            seq_d.scl_oe = 1'b1;
                            if (seq_q.bitcnt == LAST_RX) begin
                                seq_d.rdbuf = rx_shift;
                                seq_d.st    = ST_HOLD;
                                done        = 1'b1;
                            end else begin
                                seq_d.bitcnt = nxt_bit;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (hi_sampled && !seq_q.sda_oe && !sda_i) begin
                        bcol_evt     = 1'b1;
                        seq_d.st     = ST_IDLE;
                        seq_d.step   = 2'd0;
                        seq_d.scl_oe = 1'b0;
                        seq_d.sda_oe = 1'b0;
                    end else if (tick) begin
                        if (seq_q.step == 2'd0) begin
                            seq_d.step   = 2'd1;
                            seq_d.scl_oe = 1'b0;
                        end else begin
                            seq_d.st     = ST_HOLD;
                            seq_d.step   = 2'd0;
                            seq_d.scl_oe = 1'b1;
                            done         = 1'b1;
                        end
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign scl_oe   = seq_q.scl_oe;
    assign sda_oe   = seq_q.sda_oe;
    assign rd_data  = seq_q.rdbuf;
    assign ack_stat = seq_q.ack;
    assign busy     = in_xfer;

    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE) |-> (!scl_oe && !sda_oe));
    p_hold_owns_scl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_HOLD) |-> scl_oe);
    p_rx_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_RX) |-> !sda_oe);
endmodule

// File: rtl/i2c_master_core.sv
module i2c_master_core #(
    parameter int DIV_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              cmd_start,
    input  logic              cmd_rstart,
    input  logic              cmd_stop,
    input  logic              cmd_rcv,
    input  logic              cmd_ack,
    input  logic              ack_value,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_clr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack_stat,
    output logic              busy,
    output logic              sta_seen,
    output logic              sto_seen,
    output logic              irq,
    output logic              wcol,
    output logic              bcol
);
    typedef struct packed {
        logic irq;
        logic wcol;
        logic bcol;
    } flag_s;

    flag_s flg_q, flg_d;
    logic tick, brg_load, brg_hold;
    logic start_det, stop_det;
    logic seq_done, wcol_evt, bcol_evt;
    logic bus_free;

    assign brg_hold = !scl_oe && !scl_i;
    assign bus_free = sto_seen || !sta_seen;

    i2cm_brg #(.DIV_W(DIV_W)) u_brg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (brg_load),
        .hold    (brg_hold),
        .divisor (divisor),
        .tick    (tick)
    );

    i2cm_busmon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sta_seen  (sta_seen),
        .sto_seen  (sto_seen)
    );

    i2cm_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .bus_free   (bus_free),
        .cmd_start  (cmd_start),
        .cmd_rstart (cmd_rstart),
        .cmd_stop   (cmd_stop),
        .cmd_rcv    (cmd_rcv),
        .cmd_ack    (cmd_ack),
        .ack_value  (ack_value),
        .wr_strobe  (wr_strobe),
        .wr_data    (wr_data),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .tick       (tick),
        .brg_load   (brg_load),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .rd_data    (rd_data),
        .ack_stat   (ack_stat),
        .busy       (busy),
        .done       (seq_done),
        .wcol_evt   (wcol_evt),
        .bcol_evt   (bcol_evt)
    );

    always_comb begin
        flg_d      = flg_q;
        flg_d.irq  = (flg_q.irq  && !irq_clr) || start_det || stop_det || seq_done;
        flg_d.wcol = (flg_q.wcol && !irq_clr) || wcol_evt;
        flg_d.bcol = (flg_q.bcol && !irq_clr) || bcol_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign irq  = flg_q.irq;
    assign wcol = flg_q.wcol;
    assign bcol = flg_q.bcol;

    p_done_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> irq);
    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    p_wcol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && busy) |=> wcol);
    p_bcol_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bcol_evt |=> (!scl_oe && !sda_oe && !busy && bcol));
endmodule

// File: tb/i2c_master_core_tb.sv
`timescale 1ns/1ps
module i2c_master_core_tb;
    localparam int DIV = 3;
    localparam int C_START = 0, C_RSTART = 1, C_STOP = 2, C_RCV = 3,
                   C_ACK = 4, C_WR = 5, C_CLR = 6;
    // {is_rx, data, resp}: resp is the slave ack level (tx) or the ack level to send (rx)
    localparam logic [9:0] VEC [0:5] = '{
        {1'b0, 8'hA5, 1'b0},
        {1'b1, 8'h96, 1'b0},
        {1'b0, 8'hFF, 1'b0},
        {1'b1, 8'h01, 1'b1},
        {1'b0, 8'h00, 1'b0},
        {1'b0, 8'h3C, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic [6:0] divisor = 7'(DIV);
    logic cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_rcv = 0, cmd_ack = 0;
    logic ack_value = 0, wr_strobe = 0, irq_clr = 0;
    logic [7:0] wr_data = '0;
    logic tb_scl_low = 0, tb_sda_low = 0;
    wire scl_i, sda_i;
    logic scl_oe, sda_oe, ack_stat, busy, sta_seen, sto_seen, irq, wcol, bcol;
    logic [7:0] rd_data;
    int n_chk = 0, n_bad = 0;

    assign scl_i = !(scl_oe || tb_scl_low);
    assign sda_i = !(sda_oe || tb_sda_low);

    always #2.5 clk = ~clk;

    i2c_master_core u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .divisor(divisor),
        .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
        .cmd_rcv(cmd_rcv), .cmd_ack(cmd_ack), .ack_value(ack_value),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .irq_clr(irq_clr),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rd_data(rd_data), .ack_stat(ack_stat), .busy(busy),
        .sta_seen(sta_seen), .sto_seen(sto_seen), .irq(irq), .wcol(wcol), .bcol(bcol)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input int c, input logic [7:0] d);
        @(negedge clk);
        case (c)
            C_START:  cmd_start  = 1'b1;
            C_RSTART: cmd_rstart = 1'b1;
            C_STOP:   cmd_stop   = 1'b1;
            C_RCV:    cmd_rcv    = 1'b1;
            C_ACK:    cmd_ack    = 1'b1;
            C_WR:     begin wr_strobe = 1'b1; wr_data = d; end
            default:  irq_clr    = 1'b1;
        endcase
        @(negedge clk);
        {cmd_start, cmd_rstart, cmd_stop, cmd_rcv, cmd_ack, wr_strobe, irq_clr} = '0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic tx_byte(input logic [7:0] d, input logic resp, input logic stretch,
                           input logic collide, output logic [7:0] cap, output int hi);
        cap = '0;
        hi  = 0;
        if (stretch) tb_scl_low = 1'b1;
        do_cmd(C_WR, d);
        if (collide) do_cmd(C_WR, ~d);
        for (int i = 0; i < 8; i++) begin
            int n;
            if (i == 0 && stretch) begin
                repeat (30) @(negedge clk);
                tb_scl_low = 1'b0;
                #1;
            end else begin
                @(posedge scl_i);
            end
            cap = {cap[6:0], sda_i};
            n = 0;
            while (scl_i) begin @(posedge clk); #1; n++; end
            if (i == 0) hi = n;
        end
        tb_sda_low = (resp == 1'b0);
        @(posedge scl_i);
        while (scl_i) begin @(posedge clk); #1; end
        tb_sda_low = 1'b0;
        wait_idle();
    endtask

    task automatic rx_byte(input logic [7:0] d, input logic ackv,
                           output logic [7:0] got, output logic ack_seen);
        do_cmd(C_RCV, 8'h00);
        for (int i = 0; i < 8; i++) begin
            tb_sda_low = !d[7-i];
            @(posedge scl_i);
            while (scl_i) begin @(posedge clk); #1; end
        end
        tb_sda_low = 1'b0;
        wait_idle();
        got = rd_data;
        ack_value = ackv;
        do_cmd(C_ACK, 8'h00);
        @(posedge scl_i);
        ack_seen = sda_i;
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] cap, got;
        int hi;
        logic aseen;
        repeat (5) @(negedge clk);
        chk("R1 reset outputs",
            {22'd0, scl_oe, sda_oe, busy, irq, wcol, bcol, sta_seen, sto_seen, ack_stat, 1'b0},
            32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R5 / R11: START from idle
        do_cmd(C_START, 8'h00);
        wait_idle();
        chk("R2 start seen by monitor", {sta_seen, sto_seen}, 2'b10);
        chk("R2 owning with both lines low", {scl_oe, sda_oe}, 2'b11);
        chk("R5 irq after start", irq, 1'b1);
        chk("R11 ack_stat after start", ack_stat, 1'b0);

        // vector table: R5 R6 R7 R8
        for (int k = 0; k < 6; k++) begin
            logic [9:0] v;
            v = VEC[k];
            do_cmd(C_CLR, 8'h00);
            if (!v[9]) begin
                tx_byte(v[8:1], v[0], k == 0, 1'b0, cap, hi);
                chk("R7 transmitted byte MSB first", cap, v[8:1]);
                chk("R7 ack_stat from ninth clock", ack_stat, v[0]);
                chk("R6 high phase length", hi, DIV + 1);
            end else begin
                rx_byte(v[8:1], v[0], got, aseen);
                chk("R8 received byte", got, v[8:1]);
                chk("R8 ack level driven", aseen, v[0]);
            end
            chk("R5 irq after byte/ack", irq, 1'b1);
        end

        // R11: repeated START clears ack_stat left at 1 by the last vector
        do_cmd(C_CLR, 8'h00);
        do_cmd(C_RSTART, 8'h00);
        wait_idle();
        chk("R11 ack_stat cleared by rstart", ack_stat, 1'b0);
        chk("R5 irq after rstart", irq, 1'b1);
        chk("R3 rstart seen as start", {sta_seen, sto_seen}, 2'b10);

        // R9: write while busy
        do_cmd(C_CLR, 8'h00);
        tx_byte(8'h5A, 1'b0, 1'b0, 1'b1, cap, hi);
        chk("R9 wcol set", wcol, 1'b1);
        chk("R9 byte on bus unchanged", cap, 8'h5A);
        do_cmd(C_CLR, 8'h00);
        chk("R13 clear of irq and wcol", {irq, wcol}, 2'b00);

        // R11 / R3: STOP
        do_cmd(C_STOP, 8'h00);
        wait_idle();
        chk("R11 stop releases lines", {scl_oe, sda_oe, busy}, 3'b000);
        chk("R3 stop seen", {sta_seen, sto_seen}, 2'b01);
        chk("R5 irq after stop", irq, 1'b1);

        // R3 / R4: foreign START makes the bus busy, own START refused
        @(negedge clk);
        tb_sda_low = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 foreign start detected", {sta_seen, sto_seen, irq}, 3'b101);
        do_cmd(C_CLR, 8'h00);
        do_cmd(C_START, 8'h00);
        repeat (10) @(negedge clk);
        chk("R4 refused start: no activity", {busy, scl_oe, sda_oe, irq}, 4'b0000);
        tb_sda_low = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 foreign stop detected", {sta_seen, sto_seen}, 2'b01);
        do_cmd(C_CLR, 8'h00);
        do_cmd(C_START, 8'h00);
        wait_idle();
        chk("R4 start accepted after stop", {sta_seen, scl_oe}, 2'b11);

        // R10: bus collision on first bit of 0xFF
        tb_sda_low = 1'b1;
        do_cmd(C_WR, 8'hFF);
        wait_idle();
        @(negedge clk);
        chk("R10 bcol and lines released", {bcol, scl_oe, sda_oe, busy}, 4'b1000);
        tb_sda_low = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 stop after collision release", sto_seen, 1'b1);
        do_cmd(C_CLR, 8'h00);
        chk("R13 bcol cleared", bcol, 1'b0);

        // R12: disable while owning the bus
        do_cmd(C_START, 8'h00);
        wait_idle();
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 disable clears monitor and lines",
            {sta_seen, sto_seen, scl_oe, sda_oe, busy}, 5'b00000);
        enable = 1'b1;
        repeat (2) @(negedge clk);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule